// File: doc/BRIEF.md
# Presettable Synchronous Up-Counter with Cascade Carry

This block is a small synchronous up-counter whose value can be preset from a parallel data input. Two build-time parameters select the variant. The first chooses between a count that wraps after nine (decimal digit) and one that wraps after the all-ones value (binary). The second chooses whether the active-low clear acts at once or only at the next rising clock edge.

Counting needs two enables. The first is a plain count enable. The second is a chain enable, which also gates the carry output. Chaining the carry output of one stage into the chain enable of the next stage builds a wider counter. In such a chain every stage shares the clock, the clear, the load and the plain count enable.

Top module: `preset_counter`

## Requirements
- R1: Load and counting change the count only at a rising clock edge. With the synchronous-clear variant, a low clear also leaves the count unchanged until the next rising edge.
- R2: When `ld_n` is low at a rising edge and clear is high, the count takes the value of `din`, whatever the enables are.
- R3: With the asynchronous-clear variant, driving `clr_n` low forces the count to zero at once, without a clock edge.
- R4: With the synchronous-clear variant, the count becomes zero at a rising edge where `clr_n` is low. After reset the count reads zero.
- R5: Clear takes priority over load. When `clr_n` and `ld_n` are both low at an edge, the result is zero.
- R6: With clear and load high and both `cnt_en` and `chain_en` high, the count rises by one at each rising edge.
- R7: With clear and load high and either enable low, the count holds its value.
- R8: `carry_o` is 1 exactly when `chain_en` is 1 and the count equals the terminal value: 9 for the decimal variant and 15 for the binary variant. `carry_o` is 0 whenever `chain_en` is 0.
- R9: In the decimal variant an enabled count at 9 goes to 0. Presetting 7 and then counting gives 8, 9, 0, 1, 2, 3.
- R10: In the binary variant an enabled count at 15 goes to 0. Presetting 12 and then counting gives 13, 14, 15, 0, 1, 2.
- R11: In the decimal variant a preset value from 10 to 15 goes to 0 on the next enabled count.
- R12: When the carry output of one stage drives the chain enable of a second stage, the second stage advances only at the edge where the first stage wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every synchronous change happens on its rising edge |
| clr_n | input | 1 | Active-low clear (immediate or edge-timed, set by parameter) |
| ld_n | input | 1 | Active-low parallel preset |
| din | input | WIDTH | Preset value |
| cnt_en | input | 1 | Count enable, active high |
| chain_en | input | 1 | Count enable that also gates the carry, active high |
| q | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry toward the next stage |

## Verification
The clocked assertions assume that clear, load, data and enables change only away from the rising edge. They also assume that when clear goes low it stays low through at least one rising edge, so a clear pulse never starts and ends inside one cycle. The bench drives every input at the falling edge and holds clear for whole cycles. The immediate-clear variant is the one exception: its clear is checked in the middle of a cycle, and then held until the next edge. Random stimulus leans toward enabled counting so that the wrap values and the chained carry are reached often. It also loads out-of-range decimal values.

// File: rtl/cnt_pkg.sv
// Shared definitions for the presettable counter.
// Assumes WIDTH >= 4 whenever the decimal variant is chosen.
package cnt_pkg;

    // Action that the next-state logic selects for the next rising edge.
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } cnt_act_e;

    // Terminal count: nine for the decimal variant, all ones for the binary one.
    function automatic int unsigned term_count(input int unsigned width, input bit decade);
        return decade ? 9 : ((1 << width) - 1);
    endfunction

endpackage

// File: rtl/cnt_term_detect.sv
// Terminal-count detection and the gated carry output.
// Assumes the count is a plain unsigned value; values above the terminal
// count do not raise the carry, but the next-state logic wraps them.
module cnt_term_detect #(
    parameter int unsigned WIDTH  = 4,
    parameter bit          DECADE = 1'b1
) (
    input  logic [WIDTH-1:0] q,
    input  logic             chain_en,
    output logic             at_term,
    output logic             past_term,
    output logic             carry_o
);
    localparam int unsigned     TERM_I = cnt_pkg::term_count(WIDTH, DECADE);
    localparam logic [WIDTH-1:0] TERM  = WIDTH'(TERM_I);

    // Compare the count against the terminal value.
    always_comb begin
        at_term   = (q == TERM);
        past_term = (q >= TERM);
    end

    // The carry is the terminal flag gated by the chain enable.
    always_comb begin
        carry_o = at_term & chain_en;
    end
endmodule

// File: rtl/cnt_next_state.sv
// Next-state logic: load beats counting, and counting needs both enables.
// Clear is handled in the state register, because its timing depends on
// the variant. A count at or past the terminal value wraps to zero.
module cnt_next_state #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic [WIDTH-1:0] din,
    input  logic             ld_n,
    input  logic             cnt_en,
    input  logic             chain_en,
    input  logic             past_term,
    output logic [WIDTH-1:0] q_nxt
);
    import cnt_pkg::*;

    cnt_act_e act;

    // Decide the action in priority order.
    always_comb begin
        if (!ld_n)                  act = ACT_LOAD;
        else if (cnt_en && chain_en) act = ACT_STEP;
        else                        act = ACT_HOLD;
    end

    // Form the value that the register takes at the next edge.
    always_comb begin
        unique case (act)
            ACT_LOAD: q_nxt = din;
            ACT_STEP: q_nxt = past_term ? '0 : q + WIDTH'(1);
            default:  q_nxt = q;
        endcase
    end
endmodule

// File: rtl/cnt_state_reg.sv
// Count register; a parameter selects immediate or edge-timed clear.
// Assumes clr_n is glitch-free when the immediate variant is used.
module cnt_state_reg #(
    parameter int unsigned WIDTH     = 4,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] q_nxt,
    output logic [WIDTH-1:0] q
);
    generate
        if (ASYNC_CLR) begin : g_async
            // Register with a clear that acts without waiting for the clock.
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) q <= '0;
                else        q <= q_nxt;
            end
        end else begin : g_sync
            // Register with a clear sampled at the rising edge.
            always_ff @(posedge clk) begin
                if (!clr_n) q <= '0;
                else        q <= q_nxt;
            end
        end
    endgenerate
endmodule

// File: rtl/preset_counter.sv
// Top of one counter stage: register, next-state logic and carry detect.
// Stages chain by driving the next stage's chain_en from carry_o.
module preset_counter #(
    parameter int unsigned WIDTH     = 4,
    parameter bit          DECADE    = 1'b1,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic [WIDTH-1:0] din,
    input  logic             cnt_en,
    input  logic             chain_en,
    output logic [WIDTH-1:0] q,
    output logic             carry_o
);
    logic [WIDTH-1:0] q_nxt;
    logic             at_term;
    logic             past_term;
    logic             unused_term;

    // at_term is only needed inside the detector, for the carry.
    assign unused_term = at_term;

    cnt_term_detect #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
        .q(q), .chain_en(chain_en), .at_term(at_term),
        .past_term(past_term), .carry_o(carry_o)
    );

    cnt_next_state #(.WIDTH(WIDTH)) u_next (
        .q(q), .din(din), .ld_n(ld_n), .cnt_en(cnt_en),
        .chain_en(chain_en), .past_term(past_term), .q_nxt(q_nxt)
    );

    cnt_state_reg #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_reg (
        .clk(clk), .clr_n(clr_n), .q_nxt(q_nxt), .q(q)
    );
endmodule

// File: rtl/cnt_checker.sv
// Property checker for one counter stage, attached with bind.
// Assumes the inputs change away from the rising edge and that clear stays
// low across at least one rising edge.
module cnt_checker #(
    parameter int unsigned WIDTH  = 4,
    parameter bit          DECADE = 1'b1
) (
    input logic             clk,
    input logic             clr_n,
    input logic             ld_n,
    input logic [WIDTH-1:0] din,
    input logic             cnt_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] q,
    input logic             carry_o
);
    localparam logic [WIDTH-1:0] TERM = WIDTH'(cnt_pkg::term_count(WIDTH, DECADE));

    logic clr_prev = 1'b0;

    // Remember whether clear was low at the previous edge.
    always_ff @(posedge clk) clr_prev <= !clr_n;

    // R4 R5: a clear seen at an edge leaves zero, in either variant.
    p_clear_r4: assert property (@(posedge clk) clr_prev |-> (q == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_n |=> (q == $past(din)));

    p_step_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && cnt_en && chain_en && q < TERM) |=> (q == $past(q) + WIDTH'(1)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(cnt_en && chain_en)) |=> $stable(q));

    // R9 R10 R11: an enabled count at or beyond the terminal value wraps to zero.
    p_wrap_r9: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && cnt_en && chain_en && q >= TERM) |=> (q == '0));

    p_carry_gate_r8: assert property (@(posedge clk) disable iff (!clr_n)
        !chain_en |-> !carry_o);

    p_carry_term_r8: assert property (@(posedge clk) disable iff (!clr_n)
        carry_o |-> (q == TERM));
endmodule

bind preset_counter cnt_checker #(.WIDTH(WIDTH), .DECADE(DECADE)) u_chk (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din), .cnt_en(cnt_en),
    .chain_en(chain_en), .q(q), .carry_o(carry_o)
);

// File: tb/preset_counter_test.sv
`timescale 1ns/1ps
module preset_counter_test;
    logic       clk = 1'b0;
    logic       clr_n, ld_n, cnt_en, chain_en;
    logic [3:0] din_lo, din_hi;
    logic [3:0] q_lo, q_hi, q_bin;
    logic       c_lo, c_hi, c_bin;

    int checks = 0;
    int fails  = 0;

    // Bench model state and the tags for the last edge.
    logic [3:0] m_lo, m_hi, m_bin;
    string      tag_edge;

    always #2.5 clk = ~clk;

    // Decimal, edge-timed clear: lower stage of the chain.
    preset_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) uut (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din_lo), .cnt_en(cnt_en),
        .chain_en(chain_en), .q(q_lo), .carry_o(c_lo)
    );
    // Upper stage, chain enable fed by the lower carry.
    preset_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u_hi (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din_hi), .cnt_en(cnt_en),
        .chain_en(c_lo), .q(q_hi), .carry_o(c_hi)
    );
    // Binary, immediate clear.
    preset_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u_bin (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din_lo), .cnt_en(cnt_en),
        .chain_en(chain_en), .q(q_bin), .carry_o(c_bin)
    );

    function automatic logic [3:0] model_next(input logic [3:0] cur, input logic [3:0] d,
                                              input logic ld, input logic p, input logic t,
                                              input int unsigned term);
        if (!ld)      return d;
        if (p && t)   return (cur >= 4'(term)) ? 4'd0 : cur + 4'd1;
        return cur;
    endfunction

    function automatic logic model_carry(input logic [3:0] cur, input logic t,
                                         input int unsigned term);
        return t && (cur == 4'(term));
    endfunction

    // Advance the model at each rising edge from the inputs held there.
    always @(posedge clk) begin
        logic cl;
        cl = model_carry(m_lo, chain_en, 9);
        if (!clr_n)                    tag_edge = "R4";
        else if (!ld_n)                tag_edge = "R2";
        else if (cnt_en && chain_en)   tag_edge = "R6";
        else                           tag_edge = "R7";
        m_hi  = !clr_n ? 4'd0 : model_next(m_hi, din_hi, ld_n, cnt_en, cl, 9);
        m_lo  = !clr_n ? 4'd0 : model_next(m_lo, din_lo, ld_n, cnt_en, chain_en, 9);
        m_bin = !clr_n ? 4'd0 : model_next(m_bin, din_lo, ld_n, cnt_en, chain_en, 15);
    end

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check({tag_edge, " lo"}, q_lo, m_lo);
        check({tag_edge, " R12 hi"}, q_hi, m_hi);
        check({tag_edge, " R10 bin"}, q_bin, m_bin);
        check("R8 carry lo", 4'(c_lo), 4'(model_carry(m_lo, chain_en, 9)));
        check("R8 carry hi", 4'(c_hi), 4'(model_carry(m_hi, model_carry(m_lo, chain_en, 9), 9)));
        check("R8 carry bin", 4'(c_bin), 4'(model_carry(m_bin, chain_en, 15)));
    endtask

    task automatic drive(input logic c, input logic l, input logic p, input logic t,
                         input logic [3:0] dl, input logic [3:0] dh);
        clr_n = c; ld_n = l; cnt_en = p; chain_en = t; din_lo = dl; din_hi = dh;
    endtask

    // One rising edge, then compare at the following falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not end");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c47));
        m_lo = 'x; m_hi = 'x; m_bin = 'x; tag_edge = "R4";
        drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0);
        @(negedge clk);
        tick();
        tick();                                   // R4 reset state

        // R9: preset 7, then count 8, 9, 0, 1, 2, 3.
        drive(1'b1, 1'b0, 1'b0, 1'b0, 4'd7, 4'd0); tick();
        check("R2 preset 7", q_lo, 4'd7);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
        for (int i = 0; i < 6; i++) begin
            tick();
            check("R9 decimal sequence", q_lo, 4'((8 + i) % 10));
        end

        // R10: preset 12 in the binary stage.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd12, 4'd0); tick();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
        for (int i = 0; i < 6; i++) begin
            tick();
            check("R10 binary sequence", q_bin, 4'((13 + i) % 16));
        end

        // R11: an out-of-range decimal preset wraps to zero.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd13, 4'd0); tick();
        check("R11 preset 13", q_lo, 4'd13);
        check("R8 no carry at 13", 4'(c_lo), 4'd0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0); tick();
        check("R11 13 wraps to 0", q_lo, 4'd0);

        // R12: lower stage at 9, upper at 3, one count.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd9, 4'd3); tick();
        check("R8 carry at 9", 4'(c_lo), 4'd1);
        drive(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 4'd0); tick();
        check("R7 hold with cnt_en low", q_lo, 4'd9);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 4'd0);
        #1 check("R8 carry gated by chain_en", 4'(c_lo), 4'd0);
        tick();
        check("R7 hold with chain_en low", q_hi, 4'd3);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0); tick();
        check("R12 upper advances", q_hi, 4'd4);
        check("R12 lower wraps", q_lo, 4'd0);
        tick();
        check("R12 upper holds", q_hi, 4'd4);

        // R1 and R3: clear asserted mid-cycle.
        drive(1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0);
        #1;
        check("R3 immediate clear", q_bin, 4'd0);
        check("R1 edge-timed clear waits", q_lo, m_lo);
        m_bin = 4'd0;
        tick();
        check("R4 cleared at edge", q_lo, 4'd0);

        // R5: clear beats load.
        drive(1'b1, 1'b0, 1'b1, 1'b1, 4'd5, 4'd6); tick();
        drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd8, 4'd8); tick();
        check("R5 clear over load", q_lo, 4'd0);
        check("R5 clear over load hi", q_hi, 4'd0);

        // Random phase with a bias toward enabled counting.
        for (int n = 0; n < 600; n++) begin
            logic c, l;
            c = ($urandom % 24) != 0;
            l = ($urandom % 8) != 0;
            drive(c, l, ($urandom % 6) != 0, ($urandom % 5) != 0,
                  4'($urandom), 4'($urandom % 10));
            if (!c) begin
                #1 check("R3 random clear", q_bin, 4'd0);
                m_bin = 4'd0;
            end
            tick();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule